// File: doc/BRIEF.md
# Self-Correcting Decade Twisted-Ring Counter

This block counts clock edges modulo ten with a five-stage twisted ring, stages A to E. On each enabled rising edge the ring shifts one place, and the inverse of stage E enters stage A. Ones fill the ring from A until all five are set. Zeros then fill from A until only E remains set. Ten decoded digit lines mark the current count. Each line is a two-input gate on a pair of neighbouring stages, or on the A/E pair for the all-zero and all-one patterns. A carry line runs high for the first five counts and low for the last five. It forms a symmetric divide-by-ten square wave that can clock a following digit.

Only ten of the 32 five-bit patterns belong to the count loop. The path into stage C is gated so that a stray pattern is pushed back into the loop within a few clocks, with no help from outside. A synchronous load port can place any pattern in the ring. Its purpose is to expose the recovery path to test.

Top module: `johnson_decade`

## Requirements
- R1: `rst_n` low clears all five stages at once, without waiting for a clock edge. While the ring is cleared, digit 0 is the only digit that is high, and `carry_out` is 1.
- R2: With `cnt_en` high and `load_en` low, each rising edge advances the count 0,1,…,9,0. Count k (k ≤ 5) has stages 0..k-1 set (A = bit 0 … E = bit 4). Count k (k > 5) has stages 0..k-6 clear and the rest set.
- R3: On an advancing edge, stage A takes the inverse of the previous value of stage E. Stages B, D and E take the previous value of the stage before them.
- R4: On an advancing edge, stage C takes B AND (A OR C) of the previous state. It is never a plain copy of B.
- R5: Digit map: d0 = A'E', d1 = AB', d2 = BC', d3 = CD', d4 = DE', d5 = AE, d6 = A'B, d7 = B'C, d8 = C'D, d9 = D'E.
- R6: In each of the ten loop states, exactly one digit line is high. That line is the digit of the count.
- R7: `carry_out` is the inverse of stage E. It is high for counts 0–4 and low for counts 5–9.
- R8: With `cnt_en` low and `load_en` low, a rising edge leaves every stage unchanged.
- R9: With `load_en` high, a rising edge copies `load_state` (bit 0 = A) into the ring, whatever the value of `cnt_en`.
- R10: From any of the 32 patterns, at most ten advancing edges bring the ring into the loop. From then on, exactly one digit line is high after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cnt_en | input | 1 | Advance enable, active high |
| load_en | input | 1 | Synchronous pattern load, test use |
| load_state | input | 5 | Pattern to load, bit 0 = stage A |
| digit | output | 10 | Decoded count lines, bit k = count k |
| carry_out | output | 1 | Divide-by-ten square wave |

## Verification
The hard part is the recovery from the 22 stray patterns. Reset and normal counting never reach them, so the correction term in stage C stays idle. The bench uses the load port to place each of the 32 patterns in the ring, with the count held off. It then lets the ring run and compares every digit line after every edge against a behavioural model. It also confirms that a single digit line is high within ten edges and stays that way for ten more.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int unsigned JC_STAGES = 5;
  localparam int unsigned JC_DIGITS = 2 * JC_STAGES;
  localparam int unsigned JC_FIX    = 2;   // index of the gated stage (C)

  typedef logic [JC_STAGES-1:0] jc_ring_t;
  typedef logic [JC_DIGITS-1:0] jc_digit_t;

  // Pattern of loop count k, bit 0 = first stage.
  function automatic jc_ring_t jc_pattern(input int unsigned k);
    jc_ring_t r;
    for (int unsigned i = 0; i < JC_STAGES; i++) begin
      if (k <= JC_STAGES) r[i] = (i < k);
      else                r[i] = (i >= k - JC_STAGES);
    end
    return r;
  endfunction

  // True when the pattern is one of the loop states.
  function automatic logic jc_in_loop(input jc_ring_t r);
    logic hit;
    hit = 1'b0;
    for (int unsigned k = 0; k < JC_DIGITS; k++) begin
      if (jc_pattern(k) == r) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/jc_ring.sv
module jc_ring
  import jc_pkg::*;
#(
  parameter int unsigned N   = JC_STAGES,
  parameter int unsigned FIX = JC_FIX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld,
  input  logic [N-1:0] ld_val,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;
  logic         fix_term;   // gated input of the corrected stage

  assign fix_term = q[FIX-1] & (q[FIX-2] | q[FIX]);

  always_comb begin
    nxt[0] = ~q[N-1];
    for (int unsigned i = 1; i < N; i++) begin
      if (i == FIX) nxt[i] = fix_term;
      else          nxt[i] = q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (adv) q <= nxt;
  end

  p_twist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld) |=> (q[0] == !$past(q[N-1]) && q[1] == $past(q[0])));

  p_gate_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld) |=> (q[FIX] == ($past(q[FIX-1]) && ($past(q[FIX-2]) || $past(q[FIX])))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld) |=> $stable(q));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/jc_decode.sv
module jc_decode
  import jc_pkg::*;
#(
  parameter int unsigned N = JC_STAGES
) (
  input  logic [N-1:0]   q,
  output logic [2*N-1:0] d
);
  // Rising boundaries (ones filling in) and falling boundaries (zeros filling in).
  for (genvar k = 0; k < N; k++) begin : g_pair
    if (k == 0) begin : g_wrap
      assign d[0] = ~q[0] & ~q[N-1];
      assign d[N] =  q[0] &  q[N-1];
    end else begin : g_inner
      assign d[k]     =  q[k-1] & ~q[k];
      assign d[N + k] = ~q[k-1] &  q[k];
    end
  end
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
  import jc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       load_en,
  input  logic [4:0] load_state,
  output logic [9:0] digit,
  output logic       carry_out
);
  jc_ring_t  ring_q;
  jc_digit_t dig_w;
  logic      in_loop;   // present pattern is a loop state

  jc_ring #(.N(JC_STAGES), .FIX(JC_FIX)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (cnt_en),
    .ld    (load_en),
    .ld_val(load_state),
    .q     (ring_q)
  );

  jc_decode #(.N(JC_STAGES)) u_dec (
    .q(ring_q),
    .d(dig_w)
  );

  assign digit     = dig_w;
  assign carry_out = ~ring_q[JC_STAGES-1];
  assign in_loop   = jc_in_loop(ring_q);

  p_single_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_loop |-> $onehot(digit));

  p_loop_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && cnt_en && !load_en) |=> in_loop);

  p_carry_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_loop |-> (carry_out == (digit[4:0] != 5'd0)));
endmodule

// File: tb/sim_johnson_decade.sv
module sim_johnson_decade;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_state = 5'd0;
  logic [9:0] digit;
  logic       carry_out;

  int checks = 0;
  int errors = 0;
  bit [4:0] model = 5'd0;   // bit 0 = stage A

  johnson_decade u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_en(load_en),
    .load_state(load_state), .digit(digit), .carry_out(carry_out)
  );

  always #2.5 clk = ~clk;

  function automatic bit [9:0] expect_digits(input bit [4:0] s);
    bit [9:0] e;
    e = '0;
    for (int k = 0; k < 10; k++) begin
      case (k)
        0:       e[k] = (s[0] == 0) && (s[4] == 0);
        5:       e[k] = (s[0] == 1) && (s[4] == 1);
        default: if (k < 5) e[k] = s[k-1] && !s[k];
                 else       e[k] = !s[k-6] && s[k-5];
      endcase
    end
    return e;
  endfunction

  function automatic bit [4:0] advance(input bit [4:0] s);
    bit [4:0] n;
    n = {s[3:0], !s[4]};            // twisted shift toward E
    n[2] = s[1] && (s[0] || s[2]);  // gated entry of stage C
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    bit [9:0] e;
    e = expect_digits(model);
    check(digit === e && carry_out === !model[4], req, "digits/carry",
          {carry_out, digit}, {!model[4], e});
  endtask

  task automatic step(input string req);
    @(posedge clk);
    if (load_en) model = load_state;
    else if (cnt_en) model = advance(model);
    #1;
    compare(req);
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    model = 5'd0;
    compare("R1");
    check(digit === 10'b1 && carry_out === 1'b1, "R1", "reset state",
          {carry_out, digit}, 11'h401);
    @(negedge clk); rst_n = 1'b1;

    // R2 R5 R6 R7: full counting over two and a half turns
    @(negedge clk); cnt_en = 1'b1;
    for (int i = 0; i < 25; i++) begin
      step("R2");
      check($countones(digit) == 1, "R6", "one digit", {1'b0, digit}, 11'd1);
      check(carry_out === ((i + 1) % 10 < 5), "R7", "carry phase",
            {10'd0, carry_out}, {10'd0, (i + 1) % 10 < 5});
    end
    check(digit === 10'b1 << 5, "R5", "count 5 line", {1'b0, digit}, 11'h020);

    // R8: hold
    @(negedge clk); cnt_en = 1'b0;
    for (int i = 0; i < 4; i++) step("R8");
    check(digit === 10'b1 << 5, "R8", "held count", {1'b0, digit}, 11'h020);

    // R1: asynchronous clear between edges
    @(negedge clk); #1 rst_n = 1'b0; #0.5;
    model = 5'd0;
    check(digit === 10'b1 && carry_out === 1'b1, "R1", "async clear",
          {carry_out, digit}, 11'h401);
    @(negedge clk); rst_n = 1'b1;

    // R9 R10 R3 R4: every pattern, loaded with counting off, then recovered
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      cnt_en = 1'b0; load_en = 1'b1; load_state = p[4:0];
      step("R9");
      @(negedge clk); load_en = 1'b0; cnt_en = 1'b1;
      for (int c = 0; c < 10; c++) step((p % 2) ? "R4" : "R3");
      check($countones(digit) == 1, "R10", "in loop after ten edges",
            {1'b0, digit}, 11'd1);
      for (int c = 0; c < 10; c++) begin
        step("R10");
        check($countones(digit) == 1, "R10", "stays single",
              {1'b0, digit}, 11'd1);
      end
    end

    // R9: load wins over enable
    @(negedge clk); load_en = 1'b1; load_state = 5'b00111;
    step("R9");
    check(digit === 10'b1 << 3, "R9", "load with count on", {1'b0, digit}, 11'h008);
    @(negedge clk); load_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule